// File: doc/BRIEF.md
# Floating-Point Normalize and Round Stage

This block is the last stage of a single-precision add/multiply datapath. Upstream logic delivers a raw significand with a carry-out bit above the hidden-bit position, three extra low-order bits (guard, round, sticky), a tentative biased exponent that may be out of range in either direction, a sign, a two-bit exceptional-result code and a two-bit rounding mode. The stage normalizes the significand. It shifts right by one when there is a carry and left by the leading-zero count otherwise. When the normalized exponent falls below the smallest normal value, it shifts the significand right into the denormal range and folds every bit lost in that shift into the sticky bit. It then rounds in the selected mode and packs the 32-bit result together with inexact, overflow and underflow flags.

Results are accepted and delivered over a valid/ready pair held in a single output register. `in_ready` is high whenever the register is empty or its contents are being taken in the same cycle. A result that is offered while `out_ready` is low stays unchanged until the consumer takes it. The result bus is also gated by an active-low output enable.

Top module: `nr_round_stage`

## Requirements
- R1: An input is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its result is shown with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and the flags hold steady.
- R2: When the carry bit (`in_sig[24]`) is set, the significand is shifted right by one position, the exponent is raised by one, and the bit shifted out becomes the new guard bit.
- R3: With no carry, the 26-bit word {`in_sig[23:0]`, guard, round} is shifted left until its top bit is 1, the exponent is lowered by the shift count, and sticky stays below the round position.
- R4: When the normalized exponent is below 1 (tiny), the word is shifted right by 1 minus that exponent, capped at 26. Any 1 shifted out sets sticky, and the exponent field becomes 0.
- R5: Mode 00 rounds to nearest. When the value lies exactly halfway, it rounds to the neighbour whose least significant bit is 0.
- R6: Mode 01 truncates toward zero. Guard, round and sticky never change the significand.
- R7: Mode 10 rounds up in magnitude for positive results that are not exact. Mode 11 does the same for negative results. Otherwise both truncate.
- R8: A rounding increment that carries out of the significand raises the exponent by one, and a tiny result that rounds up to 1.0×2^-126 is packed as the smallest normal number.
- R9: When the final exponent field reaches 255, the result is an infinity with the input sign, and overflow and inexact are set.
- R10: Inexact is set when guard, round or sticky is nonzero after all shifts. Underflow is set when the result is tiny and inexact.
- R11: The exception code 01 gives a zero with the input sign, 10 gives +infinity and 11 gives -infinity, with every flag cleared. Code 00 selects the normal path.
- R12: While `out_en_n` is high, `out_result` reads all zeros, and the flags are not affected.
- R13: After reset, `out_valid` is low and `out_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand valid |
| in_ready | output | 1 | Stage can accept an input |
| in_sign | input | 1 | Result sign |
| in_exp | input | 10 | Tentative biased exponent, two's complement |
| in_sig | input | 25 | Raw significand, bit 24 carry, bit 23 hidden position |
| in_grs | input | 3 | Guard, round, sticky (bit 2 down to 0) |
| in_exc | input | 2 | Exception code: 00 none, 01 zero, 10 +inf, 11 -inf |
| in_rnd | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_en_n | input | 1 | Active-low result bus enable |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Result was rounded |
| out_overflow | output | 1 | Result overflowed to infinity |
| out_underflow | output | 1 | Result is tiny and inexact |

## Verification
The sweep crosses all four modes and both signs with every guard/round/sticky pattern, and with exponents that run from far below the denormal range to past the overflow limit. It also feeds significands that carry, cancel heavily, sit at all ones, or are zero. If a design lost the sticky bits during the denormal shift, it would round a tiny tail as exact or as an even tie. If it broke ties the wrong way, its low bit would be odd. If it dropped the rounding carry, the exponent would stay one too low at 2.0 and at the smallest normal. If it missed overflow in a directed mode, it would return a huge finite number. Stall, output-enable and exception-code cases confirm that the register holds its value, that the bus reads zero while disabled, and that forced codes raise no flags.

// File: rtl/nr_pkg.sv
package nr_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    EX_NONE = 2'b00,
    EX_ZERO = 2'b01,
    EX_PINF = 2'b10,
    EX_NINF = 2'b11
  } exc_code_e;
endpackage

// File: rtl/nr_lzc.sv
module nr_lzc #(
  parameter int W  = 26,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word_i,
  output logic [CW-1:0] count_o
);
  // Highest set bit wins; an all-zero word reports W.
  always_comb begin
    count_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (word_i[i]) count_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/nr_rshift_sticky.sv
module nr_rshift_sticky #(
  parameter int W  = 26,
  parameter int AW = $clog2(W + 1)
) (
  input  logic [W-1:0]  word_i,
  input  logic          sticky_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  word_o,
  output logic          sticky_o
);
  logic lost;

  always_comb begin
    word_o = word_i >> amt_i;
    lost   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(amt_i)) lost = lost | word_i[i];
    end
    sticky_o = sticky_i | lost;
  end
endmodule

// File: rtl/nr_rounder.sv
module nr_rounder
  import nr_pkg::*;
#(
  parameter int SIG_W = 24
) (
  input  logic [SIG_W-1:0] sig_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  input  logic             sign_i,
  input  logic [1:0]       mode_i,
  output logic [SIG_W:0]   sig_o,
  output logic             inexact_o
);
  logic bump;

  always_comb begin
    inexact_o = guard_i | round_i | sticky_i;
    unique case (rnd_mode_e'(mode_i))
      RM_NEAREST: bump = guard_i & (round_i | sticky_i | sig_i[0]);
      RM_ZERO:    bump = 1'b0;
      RM_UP:      bump = ~sign_i & inexact_o;
      RM_DOWN:    bump = sign_i & inexact_o;
      default:    bump = 1'b0;
    endcase
    sig_o = {1'b0, sig_i} + (SIG_W + 1)'(bump);
  end
endmodule

// File: rtl/nr_round_stage.sv
module nr_round_stage
  import nr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sign,
  input  logic [EXP_W+1:0]       in_exp,
  input  logic [MAN_W+1:0]       in_sig,
  input  logic [2:0]             in_grs,
  input  logic [1:0]             in_exc,
  input  logic [1:0]             in_rnd,
  input  logic                   out_en_n,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [EXP_W+MAN_W:0]   out_result,
  output logic                   out_inexact,
  output logic                   out_overflow,
  output logic                   out_underflow
);
  localparam int SIG_W  = MAN_W + 1;
  localparam int WORD_W = SIG_W + 2;
  localparam int EI_W   = EXP_W + 4;
  localparam int LZ_W   = $clog2(WORD_W + 1);
  localparam int DW     = EXP_W + MAN_W + 1;
  localparam logic signed [EI_W-1:0] E_ONE  = EI_W'(1);
  localparam logic signed [EI_W-1:0] E_MAX  = EI_W'((1 << EXP_W) - 1);
  localparam logic signed [EI_W-1:0] E_WORD = EI_W'(WORD_W);

  // ---------------- normalization ----------------
  logic [WORD_W-1:0]      word0, word_n, word_d;
  logic [LZ_W-1:0]        lz, amt;
  logic                   carry, st_n, st_d, word_zero, tiny;
  logic signed [EI_W-1:0] exp_ext, lz_ext, e1, dneed, e3;

  assign carry     = in_sig[SIG_W];
  assign word0     = {in_sig[SIG_W-1:0], in_grs[2:1]};
  assign word_zero = ~carry & (word0 == '0);
  assign exp_ext   = {{(EI_W-EXP_W-2){in_exp[EXP_W+1]}}, in_exp};
  assign lz_ext    = {{(EI_W-LZ_W){1'b0}}, lz};

  nr_lzc #(.W(WORD_W), .CW(LZ_W)) u_lzc (.word_i(word0), .count_o(lz));

  always_comb begin
    if (carry) begin
      word_n = {in_sig, in_grs[2]};
      st_n   = in_grs[1] | in_grs[0];
      e1     = exp_ext + E_ONE;
    end else begin
      word_n = word0 << lz;
      st_n   = in_grs[0];
      e1     = exp_ext - lz_ext;
    end
  end

  // ---------------- denormalization ----------------
  assign tiny  = word_zero | (e1 < E_ONE);
  assign dneed = E_ONE - e1;

  always_comb begin
    if (word_zero || !tiny)   amt = '0;
    else if (dneed >= E_WORD) amt = LZ_W'(WORD_W);
    else                      amt = dneed[LZ_W-1:0];
  end

  nr_rshift_sticky #(.W(WORD_W), .AW(LZ_W)) u_dnorm (
    .word_i(word_n), .sticky_i(st_n), .amt_i(amt),
    .word_o(word_d), .sticky_o(st_d)
  );

  // ---------------- rounding ----------------
  logic [SIG_W:0] rnd_sig;
  logic           rnd_inx;

  nr_rounder #(.SIG_W(SIG_W)) u_round (
    .sig_i(word_d[WORD_W-1:2]), .guard_i(word_d[1]), .round_i(word_d[0]),
    .sticky_i(st_d), .sign_i(in_sign), .mode_i(in_rnd),
    .sig_o(rnd_sig), .inexact_o(rnd_inx)
  );

  // ---------------- packing ----------------
  logic [DW-1:0]    res_d;
  logic [MAN_W-1:0] frac;
  logic             inx_d, ovf_d, unf_d;

  always_comb begin
    e3   = e1;
    frac = rnd_sig[MAN_W-1:0];
    if (tiny) begin
      e3 = rnd_sig[MAN_W] ? E_ONE : '0;
    end else if (rnd_sig[SIG_W]) begin
      e3   = e1 + E_ONE;
      frac = rnd_sig[MAN_W:1];
    end
    ovf_d = ~tiny & (e3 >= E_MAX);
    if (ovf_d) begin
      res_d = {in_sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      inx_d = 1'b1;
      unf_d = 1'b0;
    end else begin
      res_d = {in_sign, e3[EXP_W-1:0], frac};
      inx_d = rnd_inx;
      unf_d = tiny & rnd_inx;
    end
    unique case (exc_code_e'(in_exc))
      EX_ZERO: res_d = {in_sign, {(DW-1){1'b0}}};
      EX_PINF: res_d = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      EX_NINF: res_d = {1'b1, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      default: ;
    endcase
    if (in_exc != 2'b00) begin
      inx_d = 1'b0;
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end
  end

  // ---------------- output register ----------------
  logic [DW-1:0] res_q;
  logic          v_q, inx_q, ovf_q, unf_q;
  logic          fire;

  assign in_ready = ~v_q | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      res_q <= '0;
      inx_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (fire) begin
      v_q   <= 1'b1;
      res_q <= res_d;
      inx_q <= inx_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end else if (out_ready) begin
      v_q <= 1'b0;
    end
  end

  assign out_valid     = v_q;
  assign out_result    = out_en_n ? '0 : res_q;
  assign out_inexact   = inx_q;
  assign out_overflow  = ovf_q;
  assign out_underflow = unf_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_q) && $stable(inx_q)); // R1
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_exc != 2'b00 |=> !out_inexact && !out_overflow && !out_underflow); // R11
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> res_q[DW-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}} && out_inexact); // R9
  AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_inexact && !out_overflow); // R10
  AST_TRUNC_EXACT_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_exc == 2'b00 && in_sig == {2'b01, {MAN_W{1'b0}}} &&
    in_grs == 3'b000 && exp_ext > E_ONE && exp_ext < E_MAX
    |=> !out_inexact && res_q[DW-2:MAN_W] == $past(in_exp[EXP_W-1:0])); // R10
endmodule

// File: tb/nr_round_stage_test.sv
`timescale 1ns/1ps
module nr_round_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [24:0] in_sig = '0;
  logic [2:0]  in_grs = '0;
  logic [1:0]  in_exc = '0, in_rnd = '0;
  logic        out_en_n = 1'b0, out_valid, out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_inexact, out_overflow, out_underflow;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nr_round_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_grs(in_grs),
    .in_exc(in_exc), .in_rnd(in_rnd), .out_en_n(out_en_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_inexact(out_inexact), .out_overflow(out_overflow),
    .out_underflow(out_underflow)
  );

  typedef struct packed {
    logic [31:0] res;
    logic ovf, unf, inx, tiny;
  } exp_t;

  // Exact arithmetic model: value = w * 2^(ex-152) plus a sticky tail.
  function automatic exp_t model(input bit sgn, input int ex, input logic [24:0] sg,
                                 input logic [2:0] grs, input logic [1:0] exc,
                                 input logic [1:0] rnd);
    exp_t r;
    longint w, n, rem, half, pv;
    int p, lb, ee, k, sh;
    bit s, any, gt, eq, inc;
    r = '0;
    if (exc != 2'b00) begin
      r.res = (exc == 2'b01) ? {sgn, 31'h0} : (exc == 2'b10) ? 32'h7F800000 : 32'hFF800000;
      return r;
    end
    w = (longint'(sg) << 2) | longint'(grs[2:1]);
    s = grs[0];
    gt = 0; eq = 0;
    if (w == 0) begin
      n = 0; any = s; r.tiny = 1; ee = 1;
    end else begin
      p = 0;
      for (int i = 0; i < 27; i++) if (w[i]) p = i;
      lb = p + ex - 25;
      r.tiny = (lb < 1);
      ee = r.tiny ? 1 : lb;
      k = ex - ee - 2;
      if (k >= 0) begin
        n = w << k; any = s;
      end else begin
        sh = -k;
        if (sh > 40) begin
          n = 0; any = 1;
        end else begin
          n = w >> sh;
          rem = w & ((longint'(1) << sh) - 1);
          half = longint'(1) << (sh - 1);
          gt = (rem > half) || (rem == half && s);
          eq = (rem == half) && !s;
          any = (rem != 0) || s;
        end
      end
    end
    case (rnd)
      2'b00: inc = gt || (eq && n[0]);
      2'b01: inc = 0;
      2'b10: inc = !sgn && any;
      default: inc = sgn && any;
    endcase
    pv = (longint'(ee - 1) << 23) + n + longint'(inc);
    if (pv >= 64'h7F800000) begin
      r.res = {sgn, 31'h7F800000}; r.ovf = 1; r.inx = 1; r.unf = 0;
    end else begin
      r.res = {sgn, pv[30:0]}; r.inx = any; r.unf = r.tiny && any;
    end
    return r;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [34:0] act, input logic [34:0] exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic drive(input bit sgn, input int ex, input logic [24:0] sg,
                       input logic [2:0] grs, input logic [1:0] exc, input logic [1:0] rnd);
    in_sign = sgn; in_exp = 10'(ex); in_sig = sg; in_grs = grs;
    in_exc = exc; in_rnd = rnd; in_valid = 1'b1;
  endtask

  task automatic xfer(input string tag, input bit sgn, input int ex, input logic [24:0] sg,
                      input logic [2:0] grs, input logic [1:0] exc, input logic [1:0] rnd);
    exp_t e;
    e = model(sgn, ex, sg, grs, exc, rnd);
    @(negedge clk);
    drive(sgn, ex, sg, grs, exc, rnd);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_valid && out_result == e.res && out_overflow == e.ovf &&
               out_underflow == e.unf && out_inexact == e.inx,
          {out_valid, out_result, out_overflow, out_underflow, out_inexact},
          {1'b1, e.res, e.ovf, e.unf, e.inx});
  endtask

  task automatic fixed(input string tag, input bit sgn, input int ex, input logic [24:0] sg,
                       input logic [2:0] grs, input logic [1:0] exc, input logic [1:0] rnd,
                       input logic [31:0] res, input logic ovf, input logic unf, input logic inx);
    @(negedge clk);
    drive(sgn, ex, sg, grs, exc, rnd);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_result == res && out_overflow == ovf && out_underflow == unf && out_inexact == inx,
          {1'b0, out_result, out_overflow, out_underflow, out_inexact},
          {1'b0, res, ovf, unf, inx});
  endtask

  logic [24:0] sigs [8] = '{25'h0800000, 25'h0800001, 25'h0FFFFFF, 25'h1FFFFFF,
                            25'h1000001, 25'h0000003, 25'h0000000, 25'h0400000};
  int exps [10] = '{-30, -24, -2, 0, 1, 2, 127, 253, 254, 255};

  initial begin
    #200000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    string t;
    exp_t e;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13", !out_valid && out_result == 32'h0 && in_ready,
          {2'b0, out_valid, out_result}, {3'b0, 32'h0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R13", !out_valid, {34'h0, out_valid}, 35'h0);

    // Directed cases with hand-derived values
    fixed("R5",  0, 127, 25'h0800001, 3'b100, 2'b00, 2'b00, 32'h3F800002, 0, 0, 1);
    fixed("R5",  0, 127, 25'h0800000, 3'b100, 2'b00, 2'b00, 32'h3F800000, 0, 0, 1);
    fixed("R8",  0, 127, 25'h0FFFFFF, 3'b110, 2'b00, 2'b00, 32'h40000000, 0, 0, 1);
    fixed("R8",  0, 0,   25'h0FFFFFF, 3'b000, 2'b00, 2'b00, 32'h00800000, 0, 1, 1);
    fixed("R9",  0, 254, 25'h0FFFFFF, 3'b001, 2'b00, 2'b10, 32'h7F800000, 1, 0, 1);
    fixed("R6",  0, 254, 25'h0FFFFFF, 3'b001, 2'b00, 2'b01, 32'h7F7FFFFF, 0, 0, 1);
    fixed("R6",  1, 127, 25'h0800000, 3'b111, 2'b00, 2'b01, 32'hBF800000, 0, 0, 1);
    fixed("R7",  1, 127, 25'h0800000, 3'b001, 2'b00, 2'b11, 32'hBF800001, 0, 0, 1);
    fixed("R7",  1, 127, 25'h0800000, 3'b001, 2'b00, 2'b10, 32'hBF800000, 0, 0, 1);
    fixed("R11", 1, 127, 25'h0800000, 3'b111, 2'b01, 2'b10, 32'h80000000, 0, 0, 0);
    fixed("R11", 1, 254, 25'h0FFFFFF, 3'b111, 2'b10, 2'b00, 32'h7F800000, 0, 0, 0);
    fixed("R11", 0, -30, 25'h0000001, 3'b001, 2'b11, 2'b00, 32'hFF800000, 0, 0, 0);
    fixed("R3",  0, 127, 25'h0000001, 3'b000, 2'b00, 2'b00, 32'h34000000, 0, 0, 0);
    fixed("R2",  0, 127, 25'h1000001, 3'b000, 2'b00, 2'b00, 32'h40000000, 0, 0, 1);
    fixed("R10", 0, 127, 25'h0800000, 3'b000, 2'b00, 2'b00, 32'h3F800000, 0, 0, 0);
    fixed("R4",  0, -30, 25'h0800000, 3'b000, 2'b00, 2'b00, 32'h00000000, 0, 1, 1);
    fixed("R4",  0, -30, 25'h0800000, 3'b000, 2'b00, 2'b10, 32'h00000001, 0, 1, 1);
    fixed("R4",  0, 1,   25'h0400001, 3'b000, 2'b00, 2'b00, 32'h00400001, 0, 0, 0);

    // R12 output enable gating
    @(negedge clk);
    drive(0, 127, 25'h0800000, 3'b100, 2'b00, 2'b01);
    @(negedge clk);
    in_valid = 1'b0;
    out_en_n = 1'b1;
    #1;
    check("R12", out_result == 32'h0 && out_inexact, {2'b0, out_inexact, out_result}, {3'b001, 32'h0});
    out_en_n = 1'b0;
    #1;
    check("R12", out_result == 32'h3F800000, {3'b0, out_result}, {3'b0, 32'h3F800000});

    // R1 back-pressure
    @(negedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    drive(0, 127, 25'h0800000, 3'b000, 2'b00, 2'b00);
    @(negedge clk);
    drive(0, 128, 25'h0800000, 3'b000, 2'b00, 2'b00);
    check("R1", out_valid && !in_ready && out_result == 32'h3F800000,
          {1'b0, out_valid, in_ready, out_result}, {3'b010, 32'h3F800000});
    @(negedge clk);
    check("R1", out_valid && out_result == 32'h3F800000,
          {2'b0, out_valid, out_result}, {3'b001, 32'h3F800000});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", out_valid && out_result == 32'h40000000,
          {2'b0, out_valid, out_result}, {3'b001, 32'h40000000});
    @(negedge clk);
    check("R1", !out_valid, {34'h0, out_valid}, 35'h0);

    // Sweep over modes, signs, low bits, exponents and significand shapes
    for (int m = 0; m < 4; m++)
      for (int sg = 0; sg < 2; sg++)
        for (int g = 0; g < 8; g++)
          for (int xi = 0; xi < 10; xi++)
            for (int si = 0; si < 8; si++) begin
              e = model(sg[0], exps[xi], sigs[si], 3'(g), 2'b00, 2'(m));
              if (e.ovf) t = "R9";
              else if (e.tiny) t = "R4";
              else if (sigs[si][24]) t = "R2";
              else if (!sigs[si][23]) t = "R3";
              else if (m == 0) t = "R5";
              else if (m == 1) t = "R6";
              else t = "R7";
              xfer(t, sg[0], exps[xi], sigs[si], 3'(g), 2'b00, 2'(m));
            end
    for (int x = 1; x < 4; x++)
      for (int sg = 0; sg < 2; sg++)
        for (int m = 0; m < 4; m++)
          xfer("R11", sg[0], 254, 25'h1FFFFFF, 3'b111, 2'(x), 2'(m));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule